// File: doc/BRIEF.md
# RV32I Instruction Decoder

This block is the decode stage of a single-cycle RV32I datapath. It is purely combinational: a 32-bit instruction word enters, and in the same cycle it produces the three register addresses, a sign-extended immediate and the control bits that steer the rest of the datapath.

The control bits choose the two ALU operands. Operand 1 comes from the register path or from the instruction address. Operand 2 comes from the register path or from the immediate. The block also drives the data-memory read and write enables and the register-file write enable.

The decoded opcode groups are:
- upper-immediate load (LUI)
- add upper immediate to PC (AUIPC)
- jump and link (JAL)
- jump and link register (JALR)
- conditional branch
- load
- store
- register-immediate arithmetic (OP-IMM)
- register-register arithmetic (OP)

LUI is handled as "x0 + immediate". Read port 1 is forced to register 0 and operand 1 stays on the register path, so the ALU needs no pass-through mode. Any other opcode is treated as unrecognised: every enable stays low and the selects stay at their register defaults. The ALU operation encoding is not decoded here.

Top module: `rv32i_decoder`

## Requirements
- R1: `rs2_addr_o` always equals instruction bits 24:20 and `rd_addr_o` always equals bits 11:7, whatever the opcode. The opcode is bits 6:0.
- R2: `rs1_addr_o` is 0 when the opcode is LUI (0110111). For every other opcode, including unrecognised ones, it equals bits 19:15.
- R3: `op1_sel_pc_o` is 1 (instruction address) for AUIPC (0010111), JAL (1101111) and branch (1100011). It is 0 (register) for all other opcodes.
- R4: `op2_sel_imm_o` is 1 (immediate) for LUI, AUIPC, JAL, JALR (1100111), branch, load (0000011), store (0100011) and OP-IMM (0010011). It is 0 (register) for OP (0110011) and for unrecognised opcodes.
- R5: `mem_rd_en_o` is 1 only for load. `mem_wr_en_o` is 1 only for store.
- R6: `reg_wr_en_o` is 0 for store, branch and unrecognised opcodes. It is 1 for the other seven recognised opcodes.
- R7: For JALR, load and OP-IMM, `imm_o` is bits 31:20 sign-extended from bit 31.
- R8: For store, `imm_o` is {bits 31:25, bits 11:7} sign-extended from bit 31.
- R9: For branch, `imm_o` is {bit 31, bit 7, bits 30:25, bits 11:8, 0} sign-extended from bit 31. Its bit 0 is always 0.
- R10: For LUI and AUIPC, `imm_o` is bits 31:12 placed in the upper 20 bits, with the low 12 bits zero.
- R11: For JAL, `imm_o` is {bit 31, bits 19:12, bit 20, bits 30:21, 0} sign-extended from bit 31.
- R12: For an unrecognised opcode, all three enables are 0, both selects are 0 and `imm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs1_addr_o | output | 5 | Register read port 1 address |
| rs2_addr_o | output | 5 | Register read port 2 address |
| rd_addr_o | output | 5 | Write-back destination register |
| imm_o | output | XLEN (32) | Sign-extended immediate |
| op1_sel_pc_o | output | 1 | ALU operand 1 source: 1 = instruction address, 0 = register |
| op2_sel_imm_o | output | 1 | ALU operand 2 source: 1 = immediate, 0 = register |
| mem_rd_en_o | output | 1 | Data-memory read enable |
| mem_wr_en_o | output | 1 | Data-memory write enable |
| reg_wr_en_o | output | 1 | Register-file write enable |

## Verification
The hardest cases to reach are opcodes one bit away from a valid one, and immediates whose scattered bits must each land in the right place.

For the first, the stimulus sweeps all 128 opcode values with random upper bits. Every near-miss opcode is then decoded and must stay silent.

For the second, the stimulus sends each recognised opcode with pseudo-random bits above bit 6, plus directed all-ones and single-bit patterns. These catch a swapped B-type or J-type bit, a lost sign extension, and a LUI whose rs1 field is not zero.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned OPC_W  = 7;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_LUI    = 7'b0110111,
    OPC_AUIPC  = 7'b0010111,
    OPC_JAL    = 7'b1101111,
    OPC_JALR   = 7'b1100111,
    OPC_BRANCH = 7'b1100011,
    OPC_LOAD   = 7'b0000011,
    OPC_STORE  = 7'b0100011,
    OPC_OPIMM  = 7'b0010011,
    OPC_OP     = 7'b0110011
  } opc_e;

  typedef enum logic [2:0] {
    IMM_NONE = 3'd0,
    IMM_I    = 3'd1,
    IMM_S    = 3'd2,
    IMM_B    = 3'd3,
    IMM_U    = 3'd4,
    IMM_J    = 3'd5
  } imm_fmt_e;

  typedef enum logic {
    OP1_REG = 1'b0,
    OP1_PC  = 1'b1
  } op1_src_e;

  typedef enum logic {
    OP2_REG = 1'b0,
    OP2_IMM = 1'b1
  } op2_src_e;

  typedef struct packed {
    op1_src_e op1;
    op2_src_e op2;
    logic     mem_rd;
    logic     mem_wr;
    logic     reg_we;
    logic     rs1_zero;
    imm_fmt_e fmt;
  } ctrl_t;

endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o.op1      = OP1_REG;
    ctrl_o.op2      = OP2_REG;
    ctrl_o.mem_rd   = 1'b0;
    ctrl_o.mem_wr   = 1'b0;
    ctrl_o.reg_we   = 1'b0;
    ctrl_o.rs1_zero = 1'b0;
    ctrl_o.fmt      = IMM_NONE;
    case (opcode_i)
      OPC_LUI: begin
        ctrl_o.op2      = OP2_IMM;
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.rs1_zero = 1'b1;
        ctrl_o.fmt      = IMM_U;
      end
      OPC_AUIPC: begin
        ctrl_o.op1    = OP1_PC;
        ctrl_o.op2    = OP2_IMM;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.fmt    = IMM_U;
      end
      OPC_JAL: begin
        ctrl_o.op1    = OP1_PC;
        ctrl_o.op2    = OP2_IMM;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.fmt    = IMM_J;
      end
      OPC_JALR: begin
        ctrl_o.op2    = OP2_IMM;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.fmt    = IMM_I;
      end
      OPC_BRANCH: begin
        ctrl_o.op1 = OP1_PC;
        ctrl_o.op2 = OP2_IMM;
        ctrl_o.fmt = IMM_B;
      end
      OPC_LOAD: begin
        ctrl_o.op2    = OP2_IMM;
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.fmt    = IMM_I;
      end
      OPC_STORE: begin
        ctrl_o.op2    = OP2_IMM;
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.fmt    = IMM_S;
      end
      OPC_OPIMM: begin
        ctrl_o.op2    = OP2_IMM;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.fmt    = IMM_I;
      end
      OPC_OP: begin
        ctrl_o.reg_we = 1'b1;
      end
      default: begin
      end
    endcase
  end

  // Consistency between the table's columns.
  always_comb begin : chk_ctrl
    if (!$isunknown(opcode_i)) begin
      p_unknown_quiet_r12: assert (ctrl_o.fmt != IMM_NONE ||
                                   (!ctrl_o.reg_we || opcode_i == OPC_OP))
        else $error("decoder: enable raised without an immediate format");
      p_rw_exclusive_r5: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
        else $error("decoder: memory read and write both enabled");
      p_store_no_wb_r6: assert (!ctrl_o.mem_wr || !ctrl_o.reg_we)
        else $error("decoder: store also writes a register");
    end
  end

endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
  import rvdec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:7] bits_i,
  input  imm_fmt_e        fmt_i,
  output logic [XLEN-1:0] imm_o
);

  localparam int unsigned EXT_W = (XLEN > ILEN) ? XLEN - ILEN : 1;

  logic [ILEN-1:0] imm_i_v, imm_s_v, imm_b_v, imm_u_v, imm_j_v;
  logic [ILEN-1:0] raw;
  logic            sgn;

  assign sgn     = bits_i[31];
  assign imm_i_v = {{20{sgn}}, bits_i[31:20]};
  assign imm_s_v = {{20{sgn}}, bits_i[31:25], bits_i[11:7]};
  assign imm_b_v = {{19{sgn}}, sgn, bits_i[7], bits_i[30:25], bits_i[11:8], 1'b0};
  assign imm_u_v = {bits_i[31:12], 12'h000};
  assign imm_j_v = {{11{sgn}}, sgn, bits_i[19:12], bits_i[20], bits_i[30:21], 1'b0};

  always_comb begin
    case (fmt_i)
      IMM_I:   raw = imm_i_v;
      IMM_S:   raw = imm_s_v;
      IMM_B:   raw = imm_b_v;
      IMM_U:   raw = imm_u_v;
      IMM_J:   raw = imm_j_v;
      default: raw = '0;
    endcase
  end

  generate
    if (XLEN > ILEN) begin : g_wide
      logic [EXT_W-1:0] ext;
      assign ext   = {EXT_W{raw[ILEN-1]}};
      assign imm_o = {ext, raw};
    end else begin : g_native
      assign imm_o = raw[XLEN-1:0];
    end
  endgenerate

  always_comb begin : chk_imm
    if (!$isunknown({bits_i, fmt_i})) begin
      p_b_even_r9: assert (fmt_i != IMM_B || imm_o[0] == 1'b0)
        else $error("decoder: odd branch offset");
      p_j_even_r11: assert (fmt_i != IMM_J || imm_o[0] == 1'b0)
        else $error("decoder: odd jump offset");
      p_u_low_zero_r10: assert (fmt_i != IMM_U || imm_o[11:0] == 12'h000)
        else $error("decoder: upper immediate has low bits set");
      p_none_zero_r12: assert (fmt_i != IMM_NONE || imm_o == '0)
        else $error("decoder: immediate non-zero without a format");
    end
  end

endmodule

// File: rtl/rvdec_regaddr.sv
module rvdec_regaddr
  import rvdec_pkg::*;
(
  input  logic [REG_AW-1:0] rs1_fld_i,
  input  logic [REG_AW-1:0] rs2_fld_i,
  input  logic [REG_AW-1:0] rd_fld_i,
  input  logic              rs1_zero_i,
  output logic [REG_AW-1:0] rs1_addr_o,
  output logic [REG_AW-1:0] rs2_addr_o,
  output logic [REG_AW-1:0] rd_addr_o
);

  always_comb begin
    rs1_addr_o = rs1_zero_i ? '0 : rs1_fld_i;
    rs2_addr_o = rs2_fld_i;
    rd_addr_o  = rd_fld_i;
  end

endmodule

// File: rtl/rv32i_decoder.sv
module rv32i_decoder
  import rvdec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output logic [4:0]      rs1_addr_o,
  output logic [4:0]      rs2_addr_o,
  output logic [4:0]      rd_addr_o,
  output logic [XLEN-1:0] imm_o,
  output logic            op1_sel_pc_o,
  output logic            op2_sel_imm_o,
  output logic            mem_rd_en_o,
  output logic            mem_wr_en_o,
  output logic            reg_wr_en_o
);

  ctrl_t ctrl;

  rvdec_ctrl u_ctrl (
    .opcode_i (instr_i[OPC_W-1:0]),
    .ctrl_o   (ctrl)
  );

  rvdec_regaddr u_regaddr (
    .rs1_fld_i  (instr_i[19:15]),
    .rs2_fld_i  (instr_i[24:20]),
    .rd_fld_i   (instr_i[11:7]),
    .rs1_zero_i (ctrl.rs1_zero),
    .rs1_addr_o (rs1_addr_o),
    .rs2_addr_o (rs2_addr_o),
    .rd_addr_o  (rd_addr_o)
  );

  rvdec_imm #(.XLEN(XLEN)) u_imm (
    .bits_i (instr_i[ILEN-1:7]),
    .fmt_i  (ctrl.fmt),
    .imm_o  (imm_o)
  );

  assign op1_sel_pc_o  = (ctrl.op1 == OP1_PC);
  assign op2_sel_imm_o = (ctrl.op2 == OP2_IMM);
  assign mem_rd_en_o   = ctrl.mem_rd;
  assign mem_wr_en_o   = ctrl.mem_wr;
  assign reg_wr_en_o   = ctrl.reg_we;

  // Port-level relations across the sub-blocks.
  always_comb begin : chk_top
    if (!$isunknown(instr_i)) begin
      p_lui_rs1_zero_r2: assert (instr_i[6:0] != OPC_LUI || rs1_addr_o == '0)
        else $error("decoder: LUI reads a non-zero register");
      p_rd_passthru_r1: assert (rd_addr_o == instr_i[11:7] && rs2_addr_o == instr_i[24:20])
        else $error("decoder: destination or rs2 field mangled");
      p_pc_with_imm_r3: assert (!op1_sel_pc_o || op2_sel_imm_o)
        else $error("decoder: PC operand paired with register operand");
      p_load_writes_r6: assert (!mem_rd_en_o || reg_wr_en_o)
        else $error("decoder: load without register write");
      p_load_imm_r4: assert (!(mem_rd_en_o || mem_wr_en_o) || op2_sel_imm_o)
        else $error("decoder: memory access without immediate offset");
    end
  end

endmodule

// File: tb/tb_rv32i_decoder.sv
module tb_rv32i_decoder;

  localparam int unsigned WD_LIMIT = 20000;

  typedef struct {
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic        op1pc, op2imm, mrd, mwr, rwe;
    string       imm_req;
    logic        unknown;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [4:0]  rs1_a, rs2_a, rd_a;
  logic [31:0] imm;
  logic        op1pc, op2imm, mrd, mwr, rwe;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit done     = 0;
  exp_t q[$];

  rv32i_decoder dut (
    .instr_i       (instr),
    .rs1_addr_o    (rs1_a),
    .rs2_addr_o    (rs2_a),
    .rd_addr_o     (rd_a),
    .imm_o         (imm),
    .op1_sel_pc_o  (op1pc),
    .op2_sel_imm_o (op2imm),
    .mem_rd_en_o   (mrd),
    .mem_wr_en_o   (mwr),
    .reg_wr_en_o   (rwe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected values from the requirement text.
  function automatic exp_t model(logic [31:0] w, string tag);
    exp_t e;
    logic [6:0] op;
    bit lui, aui, jal, jalr, br, ld, st, oi, rr, known;
    op    = w[6:0];
    lui   = (op == 7'h37); aui = (op == 7'h17); jal = (op == 7'h6f);
    jalr  = (op == 7'h67); br  = (op == 7'h63); ld  = (op == 7'h03);
    st    = (op == 7'h23); oi  = (op == 7'h13); rr  = (op == 7'h33);
    known = lui | aui | jal | jalr | br | ld | st | oi | rr;
    e.tag     = tag;
    e.unknown = !known;
    e.rd      = w[11:7];
    e.rs2     = w[24:20];
    e.rs1     = lui ? 5'd0 : w[19:15];
    e.op1pc   = aui | jal | br;
    e.op2imm  = known & !rr;
    e.mrd     = ld;
    e.mwr     = st;
    e.rwe     = known & !st & !br;
    e.imm     = 32'd0;
    e.imm_req = "R12";
    if (jalr | ld | oi) begin
      e.imm = 32'($signed(w[31:20])); e.imm_req = "R7";
    end else if (st) begin
      e.imm = 32'($signed({w[31:25], w[11:7]})); e.imm_req = "R8";
    end else if (br) begin
      e.imm = 32'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0})); e.imm_req = "R9";
    end else if (lui | aui) begin
      e.imm = {w[31:12], 12'h000}; e.imm_req = "R10";
    end else if (jal) begin
      e.imm = 32'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0})); e.imm_req = "R11";
    end else if (rr) begin
      e.imm_req = "R12";
    end
    return e;
  endfunction

  function automatic exp_t lit(string tag, logic [4:0] r1, logic [4:0] r2, logic [4:0] d,
                               logic [31:0] im, logic p1, logic p2, logic rd_en,
                               logic wr_en, logic we, string ireq);
    exp_t e;
    e.tag = tag; e.rs1 = r1; e.rs2 = r2; e.rd = d; e.imm = im;
    e.op1pc = p1; e.op2imm = p2; e.mrd = rd_en; e.mwr = wr_en; e.rwe = we;
    e.imm_req = ireq; e.unknown = 1'b0;
    return e;
  endfunction

  task automatic chk(string req, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  // Driver: apply after the rising edge and queue the expectation.
  task automatic send(logic [31:0] w, exp_t e);
    @(posedge clk);
    #1;
    instr = w;
    q.push_back(e);
  endtask

  task automatic send_m(logic [31:0] w, string tag);
    send(w, model(w, tag));
  endtask

  // Monitor: sample on the falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string cr;
      e = q.pop_front();
      cr = e.unknown ? "R12" : "";
      chk("R1", e.tag, {27'd0, rs2_a}, {27'd0, e.rs2});
      chk("R1", e.tag, {27'd0, rd_a}, {27'd0, e.rd});
      chk("R2", e.tag, {27'd0, rs1_a}, {27'd0, e.rs1});
      chk(e.unknown ? cr : "R3", e.tag, {31'd0, op1pc}, {31'd0, e.op1pc});
      chk(e.unknown ? cr : "R4", e.tag, {31'd0, op2imm}, {31'd0, e.op2imm});
      chk(e.unknown ? cr : "R5", e.tag, {31'd0, mrd}, {31'd0, e.mrd});
      chk(e.unknown ? cr : "R5", e.tag, {31'd0, mwr}, {31'd0, e.mwr});
      chk(e.unknown ? cr : "R6", e.tag, {31'd0, rwe}, {31'd0, e.rwe});
      chk(e.imm_req, e.tag, imm, e.imm);
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] ops[9];
    ops = '{7'h37, 7'h17, 7'h6f, 7'h67, 7'h63, 7'h03, 7'h23, 7'h13, 7'h33};
    instr = 32'd0;
    rst_n = 1'b0;
    // Reset-time check: an all-zero word is an unrecognised opcode (R12).
    send_m(32'd0, "reset_zero_word");
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Directed literals.
    send(32'h00a02223, lit("store_sw", 5'd0, 5'd10, 5'd4, 32'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8"));
    send(32'h000022b7, lit("lui_small", 5'd0, 5'd0, 5'd5, 32'h00002000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10"));
    send(32'hABCDE2B7, lit("lui_rs1_field", 5'd0, 5'd28, 5'd5, 32'hABCDE000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10"));
    send(32'h002081b3, lit("add_rr", 5'd1, 5'd2, 5'd3, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R12"));
    send(32'h00208163, lit("beq_plus2", 5'd1, 5'd2, 5'd2, 32'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9"));
    send(32'hFFFFF06F, lit("jal_neg2", 5'd31, 5'd31, 5'd0, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R11"));
    send(32'hFFF00093, lit("addi_neg1", 5'd0, 5'd31, 5'd1, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7"));
    send(32'h00002003, lit("load_zero", 5'd0, 5'd0, 5'd0, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R7"));

    // Single-bit walks through every recognised opcode.
    foreach (ops[k]) begin
      for (int b = 7; b < 32; b++) begin
        send_m({(32'd1 << b) | {25'd0, ops[k]}}, "walk_bit");
      end
      send_m({25'h1FFFFFF, ops[k]}, "all_ones");
    end

    // Random upper bits for every recognised opcode.
    foreach (ops[k]) begin
      for (int n = 0; n < 40; n++) begin
        send_m({$urandom() & 32'hFFFFFF80} | {25'd0, ops[k]}, "rand_known");
      end
    end

    // Full opcode sweep, including near-miss values (R12).
    for (int o = 0; o < 128; o++) begin
      send_m({$urandom() & 32'hFFFFFF80} | o[31:0], "opcode_sweep");
      send_m(32'hFFFFFF80 | o[31:0], "opcode_sweep_ones");
    end

    // Fully random words.
    for (int n = 0; n < 300; n++) begin
      send_m($urandom(), "rand_word");
    end

    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule